// File: doc/BRIEF.md
# Multi-Channel Temperature Alert Controller

This block watches several temperature channels and drives a single active-low alert output together with per-channel status bits. Each channel presents a signed reading, a high limit, a low limit and a fault flag. Configuration inputs choose the alert mode, supply a shared hysteresis amount, and provide a global mask and one mask per channel. A one-cycle read strobe stands in for a status read by software and clears status bits.

Two alert modes are offered. In latched interrupt mode, any out-of-limit reading or fault sets a sticky status bit and pulls the alert low. The alert stays low until every such bit has been read away after its cause has gone. In hysteretic comparator mode, only over-temperature counts. The alert stays low until every channel that tripped has cooled strictly below its high limit minus the hysteresis. The high status bits then clear by themselves. The block is meant to sit behind a register interface that feeds its configuration inputs, with the alert wired toward an interrupt controller.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset, all status bits are 0 and `alert_n_o` is 1 (deasserted).
- R2: With `mode_i`=0 (interrupt mode), a channel whose reading is strictly greater than its high limit, strictly less than its low limit, or whose fault flag is 1 sets its high, low or fault status bit. If that channel is unmasked and the global mask is 0, `alert_n_o` goes low. Both take effect at the next rising clock edge, and a reading equal to a limit counts as in range.
- R3: In interrupt mode, a status bit stays set after its condition goes away. A cycle with `rd_clr_i`=1 clears only the bits whose condition is absent in that cycle. `alert_n_o` stays low while any unmasked channel has a status bit set.
- R4: In interrupt mode, `gmask_i`=1 forces `alert_n_o` high from the next clock and holds it there. Status bits keep updating as in R2 and R3.
- R5: With `mode_i`=1 (comparator mode), an unmasked channel whose reading is strictly above its high limit pulls `alert_n_o` low at the next clock. The channel stays tripped until its reading is strictly below a release level. The release level is the high limit minus `hyst_i` (unsigned), clamped at -128. The alert returns high once no unmasked channel is tripped.
- R6: In comparator mode, the high status bit of every channel that exceeds its high limit while the alert is low is set. `rd_clr_i` does not clear these bits. All high status bits clear at the same clock edge where `alert_n_o` returns high.
- R7: In comparator mode, `gmask_i` has no effect on `alert_n_o`.
- R8: A channel whose bit in `chmask_i` is 1 never causes `alert_n_o` to go low in either mode. Its status bits still update.
- R9: Low and fault status bits follow the R2 and R3 latching and read rules in both modes.
- R10: Channel i occupies bits [8i+7:8i] of each packed reading and limit bus and bit i of each per-channel vector. Readings and limits are 8-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | NCH*TW | Packed signed readings |
| hi_lim_i | input | NCH*TW | Packed signed high limits |
| lo_lim_i | input | NCH*TW | Packed signed low limits |
| fault_i | input | NCH | Per-channel fault flags |
| hyst_i | input | TW | Unsigned hysteresis for comparator release |
| mode_i | input | 1 | 0 = latched interrupt, 1 = hysteretic comparator |
| gmask_i | input | 1 | Global alert mask (interrupt mode only) |
| chmask_i | input | NCH | Per-channel alert masks |
| rd_clr_i | input | 1 | Status read strobe |
| alert_n_o | output | 1 | Registered active-low alert |
| st_hi_o | output | NCH | High-limit status bits |
| st_lo_o | output | NCH | Low-limit status bits |
| st_flt_o | output | NCH | Fault status bits |

## Verification
Interrupt mode is driven with readings exactly at a limit, one past it, below the low limit, and with faults. This separates strict from inclusive comparison and shows that each cause sets its own status bit. Read strobes are issued both after a condition has cleared and while it persists, which tells a sticky bit from one wrongly cleared. Comparator mode walks a reading up past its high limit, then down through the band above the release level, onto the release level itself and just below it. This checks that the hysteresis is strict and that status clears with the alert. Negative limits with a large hysteresis test the clamp at -128, and masks are toggled in both modes to show which mask counts where.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_HYST  = 1'b1
  } alert_mode_e;
endpackage

// File: rtl/tac_chan.sv
module tac_chan #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  input  logic [TW-1:0] hyst_i,
  output logic          over_o,
  output logic          under_o,
  output logic          hot_nxt_o
);
  localparam int EW = TW + 2;
  localparam logic signed [EW-1:0] MIN_VAL = -(2 ** (TW - 1));

  function automatic logic gt_signed(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  function automatic logic [TW-1:0] release_level(input logic [TW-1:0] hi,
                                                  input logic [TW-1:0] hy);
    logic signed [EW-1:0] diff;
    diff = $signed({{2{hi[TW-1]}}, hi}) - $signed({2'b00, hy});
    if (diff < MIN_VAL) return MIN_VAL[TW-1:0];
    return diff[TW-1:0];
  endfunction

  logic          hot_q;
  logic [TW-1:0] rel_lvl;
  logic          below_rel;

  assign over_o    = gt_signed(temp_i, hi_i);
  assign under_o   = gt_signed(lo_i, temp_i);
  assign rel_lvl   = release_level(hi_i, hyst_i);
  assign below_rel = gt_signed(rel_lvl, temp_i);

  always_comb begin
    hot_nxt_o = hot_q;
    if (over_o)         hot_nxt_o = 1'b1;
    else if (below_rel) hot_nxt_o = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_nxt_o;
  end
endmodule

// File: rtl/tac_stat.sv
module tac_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic hyst_mode_i,
  input  logic rd_clr_i,
  input  logic over_i,
  input  logic under_i,
  input  logic fault_i,
  input  logic cmp_alert_i,
  output logic sh_nxt_o,
  output logic sl_nxt_o,
  output logic sf_nxt_o,
  output logic sh_o,
  output logic sl_o,
  output logic sf_o
);
  function automatic logic sticky(input logic cond, input logic cur, input logic rd);
    return cond | (cur & ~rd);
  endfunction

  always_comb begin
    sl_nxt_o = sticky(under_i, sl_o, rd_clr_i);
    sf_nxt_o = sticky(fault_i, sf_o, rd_clr_i);
    if (hyst_mode_i) sh_nxt_o = cmp_alert_i & (sh_o | over_i);
    else             sh_nxt_o = sticky(over_i, sh_o, rd_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_o <= 1'b0;
      sl_o <= 1'b0;
      sf_o <= 1'b0;
    end else begin
      sh_o <= sh_nxt_o;
      sl_o <= sl_nxt_o;
      sf_o <= sf_nxt_o;
    end
  end
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import tac_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*TW-1:0] temp_i,
  input  logic [NCH*TW-1:0] hi_lim_i,
  input  logic [NCH*TW-1:0] lo_lim_i,
  input  logic [NCH-1:0]    fault_i,
  input  logic [TW-1:0]     hyst_i,
  input  logic              mode_i,
  input  logic              gmask_i,
  input  logic [NCH-1:0]    chmask_i,
  input  logic              rd_clr_i,
  output logic              alert_n_o,
  output logic [NCH-1:0]    st_hi_o,
  output logic [NCH-1:0]    st_lo_o,
  output logic [NCH-1:0]    st_flt_o
);
  logic           hyst_mode;
  logic [NCH-1:0] over_w, under_w, hot_nxt_w;
  logic [NCH-1:0] sh_nxt_w, sl_nxt_w, sf_nxt_w;
  logic           cmp_alert_w, int_alert_w, alert_nxt_w;
  logic           alert_n_q;

  assign hyst_mode = (mode_i == MODE_HYST);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tac_chan #(.TW(TW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .temp_i   (temp_i[g*TW +: TW]),
      .hi_i     (hi_lim_i[g*TW +: TW]),
      .lo_i     (lo_lim_i[g*TW +: TW]),
      .hyst_i   (hyst_i),
      .over_o   (over_w[g]),
      .under_o  (under_w[g]),
      .hot_nxt_o(hot_nxt_w[g])
    );

    tac_stat u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .hyst_mode_i(hyst_mode),
      .rd_clr_i   (rd_clr_i),
      .over_i     (over_w[g]),
      .under_i    (under_w[g]),
      .fault_i    (fault_i[g]),
      .cmp_alert_i(cmp_alert_w),
      .sh_nxt_o   (sh_nxt_w[g]),
      .sl_nxt_o   (sl_nxt_w[g]),
      .sf_nxt_o   (sf_nxt_w[g]),
      .sh_o       (st_hi_o[g]),
      .sl_o       (st_lo_o[g]),
      .sf_o       (st_flt_o[g])
    );
  end

  assign cmp_alert_w = |(hot_nxt_w & ~chmask_i);
  assign int_alert_w = ~gmask_i & |((sh_nxt_w | sl_nxt_w | sf_nxt_w) & ~chmask_i);
  assign alert_nxt_w = hyst_mode ? cmp_alert_w : int_alert_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n_q <= 1'b1;
    else        alert_n_q <= ~alert_nxt_w;
  end

  assign alert_n_o = alert_n_q;
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_i,
  input logic           gmask_i,
  input logic [NCH-1:0] chmask_i,
  input logic [NCH-1:0] fault_i,
  input logic           rd_clr_i,
  input logic [NCH-1:0] over_w,
  input logic           alert_n_o,
  input logic [NCH-1:0] st_hi_o,
  input logic [NCH-1:0] st_flt_o
);
  AST_INT_OVER_ALERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !gmask_i && |(over_w & ~chmask_i)) |=> !alert_n_o); // R2
  AST_FLT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((st_flt_o & $past(st_flt_o)) == $past(st_flt_o))); // R3
  AST_GMASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && gmask_i) |=> alert_n_o); // R4
  AST_CMP_OVER_ALERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && |(over_w & ~chmask_i)) |=> !alert_n_o); // R7
  AST_CMP_HI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && |(over_w & ~chmask_i)) |=> ((st_hi_o & $past(over_w)) == $past(over_w))); // R6
  AST_CMP_HI_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_n_o && $past(mode_i)) |-> (st_hi_o == '0)); // R6
  AST_FLT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_i) |=> ((st_flt_o & $past(fault_i)) == $past(fault_i))); // R9
endmodule

bind thermal_alert_ctrl tac_checker #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .gmask_i  (gmask_i),
  .chmask_i (chmask_i),
  .fault_i  (fault_i),
  .rd_clr_i (rd_clr_i),
  .over_w   (over_w),
  .alert_n_o(alert_n_o),
  .st_hi_o  (st_hi_o),
  .st_flt_o (st_flt_o)
);

// File: tb/thermal_alert_ctrl_test.sv
`timescale 1ns/1ps
module thermal_alert_ctrl_test;
  localparam int NCH = 3;
  localparam int TW  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*TW-1:0] temp_i = '0, hi_lim_i = '0, lo_lim_i = '0;
  logic [NCH-1:0]    fault_i = '0, chmask_i = '0;
  logic [TW-1:0]     hyst_i = '0;
  logic              mode_i = 1'b0, gmask_i = 1'b0, rd_clr_i = 1'b0;
  logic              alert_n_o;
  logic [NCH-1:0]    st_hi_o, st_lo_o, st_flt_o;

  always #5 clk = ~clk;

  thermal_alert_ctrl #(.NCH(NCH), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .hi_lim_i(hi_lim_i),
    .lo_lim_i(lo_lim_i), .fault_i(fault_i), .hyst_i(hyst_i), .mode_i(mode_i),
    .gmask_i(gmask_i), .chmask_i(chmask_i), .rd_clr_i(rd_clr_i),
    .alert_n_o(alert_n_o), .st_hi_o(st_hi_o), .st_lo_o(st_lo_o), .st_flt_o(st_flt_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  byte  s_t[NCH], s_h[NCH], s_l[NCH];
  bit   s_f[NCH], s_m[NCH];
  int   s_hy = 0;
  bit   s_mode = 0, s_gm = 0, s_rd = 0;

  bit   m_hot[NCH], m_sh[NCH], m_sl[NCH], m_sf[NCH];

  logic [9:0] exp_q[$];
  string      tag_q[$];

  task automatic step(input string tag);
    bit cal, ial;
    logic [9:0] e;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      temp_i[i*TW +: TW]   = s_t[i];
      hi_lim_i[i*TW +: TW] = s_h[i];
      lo_lim_i[i*TW +: TW] = s_l[i];
      fault_i[i]  = s_f[i];
      chmask_i[i] = s_m[i];
    end
    hyst_i = s_hy[7:0]; mode_i = s_mode; gmask_i = s_gm; rd_clr_i = s_rd;
    cal = 0;
    for (int i = 0; i < NCH; i++) begin
      int thr;
      thr = int'(s_h[i]) - s_hy;
      if (thr < -128) thr = -128;
      if (s_t[i] > s_h[i]) m_hot[i] = 1;
      else if (int'(s_t[i]) < thr) m_hot[i] = 0;
      if (m_hot[i] && !s_m[i]) cal = 1;
    end
    ial = 0;
    for (int i = 0; i < NCH; i++) begin
      bit ov;
      ov = s_t[i] > s_h[i];
      m_sl[i] = (s_t[i] < s_l[i]) || (m_sl[i] && !s_rd);
      m_sf[i] = s_f[i] || (m_sf[i] && !s_rd);
      if (s_mode) m_sh[i] = cal && (m_sh[i] || ov);
      else        m_sh[i] = ov || (m_sh[i] && !s_rd);
      if (!s_m[i] && (m_sh[i] || m_sl[i] || m_sf[i])) ial = 1;
    end
    if (s_gm) ial = 0;
    e[9] = s_mode ? !cal : !ial;
    for (int i = 0; i < NCH; i++) begin
      e[6+i] = m_sh[i]; e[3+i] = m_sl[i]; e[i] = m_sf[i];
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    s_rd = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [9:0] e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {alert_n_o, st_hi_o, st_lo_o, st_flt_o};
        n_chk++;
        if (g !== e) begin
          n_err++;
          $display("FAIL %s: got alert_n/hi/lo/flt=%b expected %b", t, g, e);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      s_t[i] = 25; s_h[i] = 60; s_l[i] = 10; s_f[i] = 0; s_m[i] = 0;
      m_hot[i] = 0; m_sh[i] = 0; m_sl[i] = 0; m_sf[i] = 0;
      temp_i[i*TW +: TW] = 8'd25; hi_lim_i[i*TW +: TW] = 8'd60; lo_lim_i[i*TW +: TW] = 8'd10;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if ({alert_n_o, st_hi_o, st_lo_o, st_flt_o} !== 10'b1_000_000_000) begin
      n_err++;
      $display("FAIL R1 reset: got %b expected %b",
               {alert_n_o, st_hi_o, st_lo_o, st_flt_o}, 10'b1_000_000_000);
    end

    // interrupt mode
    step("R1 idle in range");
    s_t[0] = 60;            step("R2 equal to high limit is in range");
    s_t[0] = 61;            step("R2 above high limit");
    s_t[0] = 30;            step("R3 condition gone, still sticky");
    s_rd = 1;               step("R3 read clears absent condition");
    s_h[1] = -10; s_l[1] = -20; s_t[1] = -21; step("R2 R10 negative below low");
    s_rd = 1;               step("R3 read keeps active low bit");
    s_t[1] = -15; s_rd = 1; step("R3 read clears low bit");
    s_f[2] = 1;             step("R2 fault");
    s_gm = 1;               step("R4 global mask deasserts");
    s_t[0] = 70;            step("R4 status updates while masked");
    s_gm = 0; s_f[2] = 0; s_t[0] = 20; step("R4 unmask reasserts");
    s_rd = 1;               step("R3 read clears all");
    s_m[1] = 1; s_t[1] = -30; step("R8 masked channel no alert, status set");
    s_rd = 1; s_t[1] = -15; step("R8 clean up");
    s_m[1] = 0;

    // comparator mode
    s_mode = 1; s_h[0] = 50; s_hy = 5; s_t[0] = 40; step("R5 enter comparator idle");
    s_t[0] = 51;            step("R5 R6 over asserts");
    s_t[0] = 47; s_rd = 1;  step("R6 read does not clear, R5 held in band");
    s_t[0] = 45;            step("R5 equal to release level stays");
    s_f[2] = 1;             step("R9 fault in comparator mode");
    s_f[2] = 0; s_rd = 1;   step("R9 read clears fault in comparator mode");
    s_t[0] = 44;            step("R5 R6 release and auto clear");
    s_gm = 1; s_t[2] = 61;  step("R7 global mask ignored");
    s_t[2] = 20;            step("R7 release");
    s_gm = 0; s_m[0] = 1; s_t[0] = 80; step("R8 masked channel in comparator mode");
    s_t[0] = 20;            step("R8 masked channel cools");
    s_m[0] = 0;
    s_h[1] = -120; s_hy = 20; s_t[1] = -119; step("R5 negative over");
    s_t[1] = -128;          step("R5 release level clamps at -128");
    s_hy = 0;               step("R5 release with zero hysteresis");
    s_mode = 0; s_rd = 1;   step("R3 back to interrupt mode");
    step("R1 final idle");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule